// File: doc/BRIEF.md
# Alternating Two-Side Converter Solver Scheduler

This block lets a single converter solver serve two identical converter halves: the grid-facing half and the rotor-facing half. Each fast-step tick picks one half as the working side. Its phase currents and modulating references are latched into the solver operand registers, and one solver evaluation is started. The operands also carry two history terms. The first is the working side's node voltages from its own previous evaluation, which is the one-step feedback. The second is a DC-link history value: the capacitor history current plus the three upper-arm currents that side produced last time.

When the solver reports completion, its node voltages and arm currents are captured into the working side's bank. The side's two line voltages are formed from the captured node voltages. The idle side keeps every value from its last evaluation. The working side alternates on every tick and returns to the grid half at each large-step boundary, so with an even number of fast steps per large step each half is solved the same number of times. The reference (modulation) path goes through the same selector, so one modulator serves both halves.

A solver that has not finished by the next tick sets a sticky overrun flag.

Top module: `tsds_dual_side_sched`

## Requirements
- R1: After reset, `sol_start` is 0, `sol_side` is 0 (grid), `overrun` is 0, and all four line-voltage outputs, `sol_dc_hist` and `sol_vhist` are 0.
- R2: A tick with `frame_start` high makes the grid side (`sol_side` = 0) the working side, from the cycle after the tick, whatever the previous side was.
- R3: A tick with `frame_start` low makes the other side the working side (0 = grid, 1 = rotor), from the cycle after the tick.
- R4: `sol_start` is high for exactly the one cycle after each tick and low otherwise.
- R5: `sol_cur` and `sol_ref` equal the working side's `*_cur` and `*_ref` inputs as sampled at the tick, and hold those values until the next tick even if the inputs change. Phase 0 sits in the low DW bits, phase 2 in the high bits.
- R6: `sol_dc_hist` equals `cap_hist` sampled at the tick plus the sum of the three `sol_iarm` phases captured at the working side's most recent completion (0 if that side has never completed).
- R7: `sol_vhist` equals the three node voltages captured at the working side's most recent completion (0 if none).
- R8: A `sol_done` pulse while an evaluation is pending updates the working side's outputs on the next cycle: `*_vab` = node0 − node1 and `*_vbc` = node1 − node2. The other side's outputs are unchanged.
- R9: A `sol_done` pulse while no evaluation is pending changes no output and no stored history.
- R10: A tick that arrives while an evaluation is still pending (its `sol_done` was not seen on an earlier cycle) sets `overrun`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_tick | input | 1 | Fast-step boundary pulse |
| frame_start | input | 1 | Qualifies a tick as the first fast step of a large step |
| g_cur | input | 3*DW | Grid-side phase currents, signed |
| g_ref | input | 3*DW | Grid-side modulating references, signed |
| r_cur | input | 3*DW | Rotor-side phase currents, signed |
| r_ref | input | 3*DW | Rotor-side modulating references, signed |
| cap_hist | input | DW | DC capacitor history current, signed |
| sol_start | output | 1 | One-cycle solver launch |
| sol_side | output | 1 | Working side, 0 grid, 1 rotor |
| sol_cur | output | 3*DW | Latched working-side currents |
| sol_ref | output | 3*DW | Latched working-side references |
| sol_vhist | output | 3*DW | Working side's previous node voltages |
| sol_dc_hist | output | DW+3 | Combined DC-link history term |
| sol_done | input | 1 | Solver completion pulse |
| sol_vnode | input | 3*DW | Solver node voltages, valid with sol_done |
| sol_iarm | input | 3*DW | Solver upper-arm currents, valid with sol_done |
| g_vab | output | DW+1 | Grid-side line voltage a−b |
| g_vbc | output | DW+1 | Grid-side line voltage b−c |
| r_vab | output | DW+1 | Rotor-side line voltage a−b |
| r_vbc | output | DW+1 | Rotor-side line voltage b−c |
| overrun | output | 1 | Sticky missed-deadline flag |

## Verification
The assertions assume that ticks are at least two cycles apart and that the solver raises `sol_done` only as a single-cycle pulse. They also take the capture and operand paths to move only on `sol_done` and `step_tick`. The stimulus meets these assumptions by construction. Every fast step spans several cycles, and the bench plays the solver, returning a one-cycle completion after a random delay of zero to three cycles. Some steps get an extra completion after capture to exercise R9. A closing directed sequence deliberately withholds completion so that the overrun path is reached.

// File: rtl/tsds_pkg.sv
package tsds_pkg;
  typedef enum logic {
    SIDE_GRID  = 1'b0,
    SIDE_ROTOR = 1'b1
  } side_e;

  localparam int NPH    = 3;
  localparam int NSIDES = 2;
endpackage

// File: rtl/tsds_sequencer.sv
module tsds_sequencer
  import tsds_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  step_tick,
  input  logic  frame_start,
  input  logic  done_in,
  output side_e side_nxt,
  output side_e side_q,
  output logic  launch_q,
  output logic  capture,
  output logic  overrun_q
);
  logic pending_q;

  always_comb begin
    side_nxt = frame_start ? SIDE_GRID : side_e'(~side_q);
  end

  assign capture = done_in && pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      side_q    <= SIDE_GRID;
      launch_q  <= 1'b0;
      pending_q <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      launch_q <= step_tick;
      if (step_tick) begin
        side_q    <= side_nxt;
        pending_q <= 1'b1;
        if (pending_q) overrun_q <= 1'b1;
      end else if (done_in) begin
        pending_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tsds_operand_mux.sv
module tsds_operand_mux
  import tsds_pkg::*;
#(
  parameter int DW = 16,
  localparam int VW = NPH * DW,
  localparam int AW = DW + 2,
  localparam int HW = DW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  side_e         sel,
  input  logic [VW-1:0] g_cur,
  input  logic [VW-1:0] g_ref,
  input  logic [VW-1:0] r_cur,
  input  logic [VW-1:0] r_ref,
  input  logic [DW-1:0] cap_hist,
  input  logic [VW-1:0] g_vprev,
  input  logic [VW-1:0] r_vprev,
  input  logic [AW-1:0] g_arm,
  input  logic [AW-1:0] r_arm,
  output logic [VW-1:0] op_cur,
  output logic [VW-1:0] op_ref,
  output logic [VW-1:0] op_vhist,
  output logic [HW-1:0] op_dc_hist
);
  for (genvar p = 0; p < NPH; p++) begin : g_phase
    always_ff @(posedge clk) begin
      if (rst) begin
        op_cur[p*DW +: DW]   <= '0;
        op_ref[p*DW +: DW]   <= '0;
        op_vhist[p*DW +: DW] <= '0;
      end else if (load) begin
        op_cur[p*DW +: DW]   <= (sel == SIDE_ROTOR) ? r_cur[p*DW +: DW]   : g_cur[p*DW +: DW];
        op_ref[p*DW +: DW]   <= (sel == SIDE_ROTOR) ? r_ref[p*DW +: DW]   : g_ref[p*DW +: DW];
        op_vhist[p*DW +: DW] <= (sel == SIDE_ROTOR) ? r_vprev[p*DW +: DW] : g_vprev[p*DW +: DW];
      end
    end
  end

  logic [AW-1:0] arm_sel;
  logic [HW-1:0] dc_sum;

  always_comb begin
    arm_sel = (sel == SIDE_ROTOR) ? r_arm : g_arm;
    dc_sum  = {{(HW-DW){cap_hist[DW-1]}}, cap_hist} + {arm_sel[AW-1], arm_sel};
  end

  always_ff @(posedge clk) begin
    if (rst)       op_dc_hist <= '0;
    else if (load) op_dc_hist <= dc_sum;
  end
endmodule

// File: rtl/tsds_result_bank.sv
module tsds_result_bank
  import tsds_pkg::*;
#(
  parameter int DW = 16,
  localparam int VW = NPH * DW,
  localparam int AW = DW + 2,
  localparam int LW = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 capture,
  input  side_e                side,
  input  logic [VW-1:0]        vnode,
  input  logic [VW-1:0]        iarm,
  output logic [NSIDES*VW-1:0] vprev,
  output logic [NSIDES*AW-1:0] armsum,
  output logic [NSIDES*LW-1:0] lv_ab,
  output logic [NSIDES*LW-1:0] lv_bc
);
  logic [AW-1:0] arm_total;
  logic [LW-1:0] diff_ab, diff_bc;

  always_comb begin
    arm_total = '0;
    for (int p = 0; p < NPH; p++) begin
      arm_total = arm_total + {{(AW-DW){iarm[p*DW+DW-1]}}, iarm[p*DW +: DW]};
    end
    diff_ab = {vnode[DW-1], vnode[0 +: DW]} - {vnode[2*DW-1], vnode[DW +: DW]};
    diff_bc = {vnode[2*DW-1], vnode[DW +: DW]} - {vnode[3*DW-1], vnode[2*DW +: DW]};
  end

  for (genvar s = 0; s < NSIDES; s++) begin : g_side
    logic hit;
    assign hit = capture && (side == side_e'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        vprev[s*VW +: VW]  <= '0;
        armsum[s*AW +: AW] <= '0;
        lv_ab[s*LW +: LW]  <= '0;
        lv_bc[s*LW +: LW]  <= '0;
      end else if (hit) begin
        vprev[s*VW +: VW]  <= vnode;
        armsum[s*AW +: AW] <= arm_total;
        lv_ab[s*LW +: LW]  <= diff_ab;
        lv_bc[s*LW +: LW]  <= diff_bc;
      end
    end
  end
endmodule

// File: rtl/tsds_dual_side_sched.sv
module tsds_dual_side_sched
  import tsds_pkg::*;
#(
  parameter int DW = 16,
  localparam int VW = NPH * DW,
  localparam int AW = DW + 2,
  localparam int LW = DW + 1,
  localparam int HW = DW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_tick,
  input  logic          frame_start,
  input  logic [VW-1:0] g_cur,
  input  logic [VW-1:0] g_ref,
  input  logic [VW-1:0] r_cur,
  input  logic [VW-1:0] r_ref,
  input  logic [DW-1:0] cap_hist,
  output logic          sol_start,
  output logic          sol_side,
  output logic [VW-1:0] sol_cur,
  output logic [VW-1:0] sol_ref,
  output logic [VW-1:0] sol_vhist,
  output logic [HW-1:0] sol_dc_hist,
  input  logic          sol_done,
  input  logic [VW-1:0] sol_vnode,
  input  logic [VW-1:0] sol_iarm,
  output logic [LW-1:0] g_vab,
  output logic [LW-1:0] g_vbc,
  output logic [LW-1:0] r_vab,
  output logic [LW-1:0] r_vbc,
  output logic          overrun
);
  side_e side_nxt, side_q;
  logic  capture;
  logic [NSIDES*VW-1:0] vprev;
  logic [NSIDES*AW-1:0] armsum;
  logic [NSIDES*LW-1:0] lv_ab, lv_bc;

  tsds_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .step_tick  (step_tick),
    .frame_start(frame_start),
    .done_in    (sol_done),
    .side_nxt   (side_nxt),
    .side_q     (side_q),
    .launch_q   (sol_start),
    .capture    (capture),
    .overrun_q  (overrun)
  );

  tsds_operand_mux #(.DW(DW)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .load      (step_tick),
    .sel       (side_nxt),
    .g_cur     (g_cur),
    .g_ref     (g_ref),
    .r_cur     (r_cur),
    .r_ref     (r_ref),
    .cap_hist  (cap_hist),
    .g_vprev   (vprev[0 +: VW]),
    .r_vprev   (vprev[VW +: VW]),
    .g_arm     (armsum[0 +: AW]),
    .r_arm     (armsum[AW +: AW]),
    .op_cur    (sol_cur),
    .op_ref    (sol_ref),
    .op_vhist  (sol_vhist),
    .op_dc_hist(sol_dc_hist)
  );

  tsds_result_bank #(.DW(DW)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .capture(capture),
    .side   (side_q),
    .vnode  (sol_vnode),
    .iarm   (sol_iarm),
    .vprev  (vprev),
    .armsum (armsum),
    .lv_ab  (lv_ab),
    .lv_bc  (lv_bc)
  );

  assign sol_side = side_q;
  assign g_vab    = lv_ab[0 +: LW];
  assign g_vbc    = lv_bc[0 +: LW];
  assign r_vab    = lv_ab[LW +: LW];
  assign r_vbc    = lv_bc[LW +: LW];
endmodule

// File: rtl/tsds_checker.sv
module tsds_checker #(
  parameter int DW = 16,
  localparam int VW = 3 * DW,
  localparam int LW = DW + 1,
  localparam int HW = DW + 3
) (
  input logic          clk,
  input logic          rst,
  input logic          step_tick,
  input logic          frame_start,
  input logic          sol_start,
  input logic          sol_side,
  input logic [VW-1:0] sol_cur,
  input logic [VW-1:0] sol_ref,
  input logic [HW-1:0] sol_dc_hist,
  input logic          sol_done,
  input logic [LW-1:0] g_vab,
  input logic [LW-1:0] g_vbc,
  input logic [LW-1:0] r_vab,
  input logic [LW-1:0] r_vbc,
  input logic          overrun
);
  a_r2_frame_to_grid: assert property (@(posedge clk) disable iff (rst)
    step_tick && frame_start |=> sol_side == 1'b0);

  a_r3_side_toggles: assert property (@(posedge clk) disable iff (rst)
    step_tick && !frame_start |=> sol_side != $past(sol_side));

  a_r4_start_follows_tick: assert property (@(posedge clk) disable iff (rst)
    step_tick |=> sol_start);

  a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
    sol_start |=> !sol_start);

  a_r5_operands_held: assert property (@(posedge clk) disable iff (rst)
    !step_tick |=> $stable(sol_cur) && $stable(sol_ref));

  a_r6_dc_hist_held: assert property (@(posedge clk) disable iff (rst)
    !step_tick |=> $stable(sol_dc_hist));

  a_r9_outputs_need_done: assert property (@(posedge clk) disable iff (rst)
    !sol_done |=> $stable(g_vab) && $stable(g_vbc) && $stable(r_vab) && $stable(r_vbc));

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind tsds_dual_side_sched tsds_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step_tick  (step_tick),
  .frame_start(frame_start),
  .sol_start  (sol_start),
  .sol_side   (sol_side),
  .sol_cur    (sol_cur),
  .sol_ref    (sol_ref),
  .sol_dc_hist(sol_dc_hist),
  .sol_done   (sol_done),
  .g_vab      (g_vab),
  .g_vbc      (g_vbc),
  .r_vab      (r_vab),
  .r_vbc      (r_vbc),
  .overrun    (overrun)
);

// File: tb/tsds_dual_side_sched_test.sv
`timescale 1ns/1ps
module tsds_dual_side_sched_test;
  localparam int DW = 16;
  localparam int VW = 3 * DW;
  localparam int LW = DW + 1;
  localparam int HW = DW + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_tick = 1'b0, frame_start = 1'b0, sol_done = 1'b0;
  logic [VW-1:0] g_cur = '0, g_ref = '0, r_cur = '0, r_ref = '0;
  logic [DW-1:0] cap_hist = '0;
  logic [VW-1:0] sol_vnode = '0, sol_iarm = '0;
  logic sol_start, sol_side, overrun;
  logic [VW-1:0] sol_cur, sol_ref, sol_vhist;
  logic [HW-1:0] sol_dc_hist;
  logic [LW-1:0] g_vab, g_vbc, r_vab, r_vbc;

  always #2.5 clk = ~clk;

  tsds_dual_side_sched #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .step_tick(step_tick), .frame_start(frame_start),
    .g_cur(g_cur), .g_ref(g_ref), .r_cur(r_cur), .r_ref(r_ref), .cap_hist(cap_hist),
    .sol_start(sol_start), .sol_side(sol_side), .sol_cur(sol_cur), .sol_ref(sol_ref),
    .sol_vhist(sol_vhist), .sol_dc_hist(sol_dc_hist), .sol_done(sol_done),
    .sol_vnode(sol_vnode), .sol_iarm(sol_iarm),
    .g_vab(g_vab), .g_vbc(g_vbc), .r_vab(r_vab), .r_vbc(r_vbc), .overrun(overrun)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // bench model of per-side state
  logic [VW-1:0] m_vst [2];
  longint        m_arm [2];
  longint        m_ab  [2];
  longint        m_bc  [2];
  bit            m_side;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ph(input logic [VW-1:0] v, input int p);
    logic signed [DW-1:0] x;
    x = v[p*DW +: DW];
    return longint'(x);
  endfunction

  function automatic longint sx(input logic [LW-1:0] v);
    logic signed [LW-1:0] x;
    x = v;
    return longint'(x);
  endfunction

  function automatic longint sxh(input logic [HW-1:0] v);
    logic signed [HW-1:0] x;
    x = v;
    return longint'(x);
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    return {16'($urandom), 16'($urandom), 16'($urandom)};
  endfunction

  task automatic scramble_inputs();
    g_cur = rnd_vec(); g_ref = rnd_vec();
    r_cur = rnd_vec(); r_ref = rnd_vec();
    cap_hist = 16'($urandom);
  endtask

  task automatic check_lines(input string req);
    chk({req, " g_vab"}, sx(g_vab), m_ab[0]);
    chk({req, " g_vbc"}, sx(g_vbc), m_bc[0]);
    chk({req, " r_vab"}, sx(r_vab), m_ab[1]);
    chk({req, " r_vbc"}, sx(r_vbc), m_bc[1]);
  endtask

  // one fast step: tick, operand checks, solver reply after lat cycles
  task automatic run_step(input bit fr, input int lat, input bit extra_done);
    logic [VW-1:0] e_cur, e_ref;
    longint e_dc;
    m_side = fr ? 1'b0 : ~m_side;
    scramble_inputs();
    e_cur = m_side ? r_cur : g_cur;
    e_ref = m_side ? r_ref : g_ref;
    e_dc  = longint'($signed(cap_hist)) + m_arm[m_side];
    step_tick = 1'b1; frame_start = fr;
    @(negedge clk);
    step_tick = 1'b0; frame_start = 1'b0;
    chk("R4 start pulse", longint'(sol_start), 1);
    chk(fr ? "R2 side" : "R3 side", longint'(sol_side), longint'(m_side));
    chk("R5 cur", longint'(sol_cur), longint'(e_cur));
    chk("R5 ref", longint'(sol_ref), longint'(e_ref));
    chk("R7 vhist", longint'(sol_vhist), longint'(m_vst[m_side]));
    chk("R6 dc hist", sxh(sol_dc_hist), e_dc);
    scramble_inputs();
    @(negedge clk);
    chk("R4 start low", longint'(sol_start), 0);
    chk("R5 held cur", longint'(sol_cur), longint'(e_cur));
    chk("R5 held ref", longint'(sol_ref), longint'(e_ref));
    repeat (lat) @(negedge clk);
    sol_vnode = rnd_vec(); sol_iarm = rnd_vec(); sol_done = 1'b1;
    m_vst[m_side] = sol_vnode;
    m_arm[m_side] = ph(sol_iarm, 0) + ph(sol_iarm, 1) + ph(sol_iarm, 2);
    m_ab[m_side]  = ph(sol_vnode, 0) - ph(sol_vnode, 1);
    m_bc[m_side]  = ph(sol_vnode, 1) - ph(sol_vnode, 2);
    @(negedge clk);
    sol_done = 1'b0;
    check_lines("R8");
    if (extra_done) begin
      sol_vnode = rnd_vec(); sol_iarm = rnd_vec(); sol_done = 1'b1;
      @(negedge clk);
      sol_done = 1'b0;
      check_lines("R9");
    end
    chk("R10 no overrun", longint'(overrun), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 2; s++) begin
      m_vst[s] = '0; m_arm[s] = 0; m_ab[s] = 0; m_bc[s] = 0;
    end
    m_side = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 start", longint'(sol_start), 0);
    chk("R1 side", longint'(sol_side), 0);
    chk("R1 overrun", longint'(overrun), 0);
    chk("R1 dc hist", longint'(sol_dc_hist), 0);
    chk("R1 vhist", longint'(sol_vhist), 0);
    check_lines("R1");

    // R9 directed: completion with nothing pending
    sol_vnode = rnd_vec(); sol_iarm = rnd_vec(); sol_done = 1'b1;
    @(negedge clk);
    sol_done = 1'b0;
    check_lines("R9 idle");

    // random steps, large step of 4 fast steps, plus a back-to-back frame at 21
    for (int k = 0; k < 48; k++) begin
      run_step((k % 4 == 0) || (k == 21), int'($urandom_range(0, 3)), (k % 3 == 0));
    end

    // R10 directed: launch without completion, then tick again
    m_side = ~m_side;
    step_tick = 1'b1;
    @(negedge clk);
    step_tick = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 before deadline", longint'(overrun), 0);
    step_tick = 1'b1;
    @(negedge clk);
    step_tick = 1'b0;
    chk("R10 set", longint'(overrun), 1);
    sol_done = 1'b1;
    @(negedge clk);
    sol_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 sticky", longint'(overrun), 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule